// File: doc/BRIEF.md
# Receive Comma Aligner and Framer

This block sits behind a clock-and-data-recovery front end. It accepts one recovered bit per bit clock and finds the 10-bit character boundaries in that stream. It searches the newest ten bits for the negative-disparity comma prefix. When the prefix appears at a phase other than the one in use, the block moves its word boundary to that point. From then on it delivers aligned 10-bit characters with a one-cycle word strobe. A K28.5 character of either disparity that falls on the boundary is marked with a frame pulse. The first word delivered after a boundary move is marked with an alignment-changed flag.

Comma search runs only while the enable is high. With the enable low, the bit stream still leaves the block in 10-bit words at the phase last set, unframed. The block keeps a 10-bit lookahead so that a realignment never shortens a word period: the partial word that straddles the old and new boundaries is dropped, and that one period is stretched instead.

Top module: `comma_aligner`

## Requirements
- R1: The first bit received after a boundary lands in bit 0 of the delivered word. After alignment, the delivered words equal the transmitted characters in order.
- R2: The boundary moves only when the newest 10 bits hold the prefix bit0..bit6 = 0,0,1,1,1,1,1 (word[6:0] = 7'b1111100) at a phase different from the current one. The first word delivered after the move is that comma character.
- R3: The inverted prefix 1,1,0,0,0,0,0 (word[6:0] = 7'b0000011) never moves the boundary.
- R4: While comma_en is low, the boundary never moves. Words keep coming every 10 bit clocks at the old phase, with no alignment-changed flag.
- R5: In steady state word_vld pulses once every 10 bit clocks and is never closer than 10 cycles to the previous pulse. The period that contains a boundary move lasts between 11 and 19 cycles.
- R6: frame_pls is high with word_vld exactly when the delivered word is 10'h17C or 10'h283 (K28.5, bit 0 first), and low otherwise.
- R7: align_chg is high for exactly one word: the first word delivered after a boundary move.
- R8: While reset is held, word_o, word_vld, frame_pls and align_chg are all zero.
- R9: A comma that already lies on the current boundary is framed but does not raise align_chg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Recovered serial data bit |
| comma_en | input | 1 | Allows realignment on the comma prefix |
| word_o | output | 10 | Aligned character, bit 0 received first |
| word_vld | output | 1 | One-cycle strobe for each delivered word |
| frame_pls | output | 1 | Delivered word is K28.5 of either disparity |
| align_chg | output | 1 | First word after a boundary move |

## Verification
The stream starts with a 3-bit slip ahead of a negative comma. This shows whether the first realignment happens, whether the stretched period falls between 11 and 19 cycles, and whether the data that follows comes out intact with bit 0 first. The enable-low pattern slips the stream and sends a comma that must be ignored, then raises the enable so the same comma must realign. This separates gating by the enable from gating by pattern. A 4-bit slip followed by a positive-disparity K28.5 confirms that the inverted prefix does not realign and that misaligned commas are not framed. A final stream with both K28.5 forms on the boundary confirms that framing does not depend on disparity and that an aligned comma raises no change flag.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CHAR_W = 10;
  localparam int PRE_W  = 7;
  localparam int HIST_W = 2 * CHAR_W;
  localparam int PH_W   = $clog2(CHAR_W);

  localparam logic [PRE_W-1:0]  NEG_PREFIX = 7'b1111100;
  localparam logic [CHAR_W-1:0] K285_NEG   = 10'b0101111100;
  localparam logic [CHAR_W-1:0] K285_POS   = 10'b1010000011;

  function automatic logic has_neg_prefix(input logic [CHAR_W-1:0] w);
    return (w[PRE_W-1:0] == NEG_PREFIX);
  endfunction

  function automatic logic has_pos_prefix(input logic [CHAR_W-1:0] w);
    return (w[PRE_W-1:0] == ~NEG_PREFIX);
  endfunction

  function automatic logic is_k285(input logic [CHAR_W-1:0] w);
    return (w == K285_NEG) || (w == K285_POS);
  endfunction

  function automatic int unsigned next_phase(input int unsigned cur);
    return (cur >= CHAR_W - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/cal_bit_history.sv
module cal_bit_history
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  output logic [CHAR_W-1:0] newest,
  output logic [CHAR_W-1:0] oldest
);
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {ser_bit, hist[HIST_W-1:1]};
  end

  assign newest = hist[HIST_W-1:CHAR_W];
  assign oldest = hist[CHAR_W-1:0];
endmodule

// File: rtl/cal_comma_detect.sv
module cal_comma_detect
  import cal_pkg::*;
(
  input  logic              en,
  input  logic              tick,
  input  logic [CHAR_W-1:0] window,
  output logic              comma_seen,
  output logic              realign
);
  always_comb begin
    comma_seen = has_neg_prefix(window);
    realign    = en && comma_seen && !tick;
  end
endmodule

// File: rtl/cal_word_phase.sv
module cal_word_phase
  import cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            realign,
  output logic [PH_W-1:0] phase,
  output logic            tick,
  output logic            pending
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CHAR_W - 1);

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      pending <= 1'b0;
    end else if (realign) begin
      phase   <= '0;
      pending <= 1'b1;
    end else begin
      phase <= PH_W'(next_phase(int'(phase)));
      if (tick) pending <= 1'b0;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST); // R5
  AST_REALIGN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (phase == '0) && pending); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!realign && !tick) |=> phase == PH_W'($past(phase) + 1'b1)); // R5
endmodule

// File: rtl/cal_word_emit.sv
module cal_word_emit
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              chg_in,
  input  logic [CHAR_W-1:0] word_in,
  output logic [CHAR_W-1:0] word_o,
  output logic              word_vld,
  output logic              frame_pls,
  output logic              align_chg
);
  localparam int GAP_W = $clog2(2 * CHAR_W) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_o    <= '0;
      word_vld  <= 1'b0;
      frame_pls <= 1'b0;
      align_chg <= 1'b0;
    end else begin
      word_vld <= tick;
      if (tick) begin
        word_o    <= word_in;
        frame_pls <= is_k285(word_in);
        align_chg <= chg_in;
      end else begin
        frame_pls <= 1'b0;
        align_chg <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             gap <= GAP_MAX;
    else if (word_vld)      gap <= GAP_W'(1);
    else if (gap != GAP_MAX) gap <= gap + 1'b1;
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> gap >= GAP_W'(CHAR_W)); // R5
  AST_FRAME_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pls |-> word_vld); // R6
  AST_CHG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    align_chg |-> word_vld); // R7
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              comma_en,
  output logic [CHAR_W-1:0] word_o,
  output logic              word_vld,
  output logic              frame_pls,
  output logic              align_chg
);
  logic [CHAR_W-1:0] newest_w;
  logic [CHAR_W-1:0] oldest_w;
  logic              comma_seen;
  logic              realign;
  logic              tick;
  logic              pending;
  logic [PH_W-1:0]   phase;

  cal_bit_history u_hist (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
    .newest(newest_w), .oldest(oldest_w)
  );

  cal_comma_detect u_det (
    .en(comma_en), .tick(tick), .window(newest_w),
    .comma_seen(comma_seen), .realign(realign)
  );

  cal_word_phase u_phase (
    .clk(clk), .rst_n(rst_n), .realign(realign),
    .phase(phase), .tick(tick), .pending(pending)
  );

  cal_word_emit u_emit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chg_in(pending),
    .word_in(oldest_w), .word_o(word_o), .word_vld(word_vld),
    .frame_pls(frame_pls), .align_chg(align_chg)
  );

  AST_COMPLEMENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (has_pos_prefix(newest_w) && !comma_seen) |-> !realign); // R3
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!comma_en && !tick) |=> phase == PH_W'($past(phase) + 1'b1)); // R4
  AST_CHG_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    align_chg |-> has_neg_prefix(word_o)); // R7
  AST_ALIGNED_COMMA_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_seen && tick) |=> phase == '0 && !pending); // R9
endmodule

// File: tb/sim_comma_aligner.sv
module sim_comma_aligner;
  localparam int CLK_P = 10;
  localparam logic [9:0] KN = 10'h17C;
  localparam logic [9:0] KP = 10'h283;
  localparam logic [9:0] DA = 10'h155;
  localparam logic [9:0] DB = 10'h2AA;

  logic clk = 1'b0;
  logic rst_n, ser_bit, comma_en;
  logic [9:0] word_o;
  logic word_vld, frame_pls, align_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [9:0] lw [0:511];
  bit lf [0:511];
  bit lc [0:511];
  int lt [0:511];
  int ln = 0;
  int cyc = 0;
  bit log_on = 0;

  logic [9:0] exp_w [0:3];
  bit exp_f [0:3];

  always #(CLK_P/2) clk = ~clk;

  comma_aligner u0 (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .comma_en(comma_en),
    .word_o(word_o), .word_vld(word_vld), .frame_pls(frame_pls), .align_chg(align_chg)
  );

  always @(negedge clk) begin
    cyc++;
    if (log_on && word_vld && ln < 512) begin
      lw[ln] = word_o; lf[ln] = frame_pls; lc[ln] = align_chg; lt[ln] = cyc;
      ln++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_bit = b;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic pad();
    for (int i = 0; i < 3; i++) send_word(DA);
  endtask

  task automatic analyze_realign(input string tag);
    int k = -1;
    int nchg = 0;
    for (int i = 0; i < ln; i++) if (lc[i]) begin nchg++; if (k < 0) k = i; end
    chk(nchg == 1, "R7 single change flag", nchg, 1);
    if (k < 1) begin
      chk(0, "R2 realign not seen", k, 1);
      return;
    end
    chk(lw[k] == KN, "R2 first word after move is comma", lw[k], KN);
    chk(lf[k] == 1, "R6 comma framed", lf[k], 1);
    chk((lt[k] - lt[k-1]) > 10 && (lt[k] - lt[k-1]) < 20, "R5 stretched period", lt[k] - lt[k-1], 13);
    for (int j = 1; j <= 4; j++) begin
      if (k + j >= ln) begin
        chk(0, "R1 missing word", k + j, ln);
      end else begin
        chk(lw[k+j] == exp_w[j-1], "R1 aligned data", lw[k+j], exp_w[j-1]);
        chk(lf[k+j] == exp_f[j-1], "R6 frame flag", lf[k+j], exp_f[j-1]);
        chk(lt[k+j] - lt[k+j-1] == 10, "R5 word period", lt[k+j] - lt[k+j-1], 10);
        if (exp_w[j-1] == KN) chk(lc[k+j] == 0, "R9 aligned comma keeps boundary", lc[k+j], 0);
      end
    end
    $display("scenario %s analysed", tag);
  endtask

  task automatic analyze_quiet(input string req);
    int nchg = 0;
    int nfr = 0;
    int bad = 0;
    for (int i = 0; i < ln; i++) begin
      if (lc[i]) nchg++;
      if (lf[i]) nfr++;
      if (i > 0 && lt[i] - lt[i-1] != 10) bad++;
    end
    chk(nchg == 0, req, nchg, 0);
    chk(nfr == 0, "R6 no frame on misaligned stream", nfr, 0);
    chk(bad == 0, "R5 period kept at old phase", bad, 0);
    chk(ln >= 3, "R4 words still delivered", ln, 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; comma_en = 1'b1; ser_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(word_o == 0 && !word_vld && !frame_pls && !align_chg, "R8 reset outputs", {word_o, word_vld, frame_pls, align_chg}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_align();
    ln = 0; log_on = 1;
    send_bit(1); send_bit(0); send_bit(1);
    send_word(KN); send_word(DA); send_word(DB); send_word(DA); send_word(DB);
    pad();
    exp_w[0] = DA; exp_w[1] = DB; exp_w[2] = DA; exp_w[3] = DB;
    exp_f[0] = 0; exp_f[1] = 0; exp_f[2] = 0; exp_f[3] = 0;
    analyze_realign("first alignment R1 R2");
  endtask

  task automatic t_enable_low();
    ln = 0;
    comma_en = 1'b0;
    send_bit(1); send_bit(0); send_bit(1);
    send_word(KN); send_word(DA); send_word(DB);
    pad();
    analyze_quiet("R4 no change while disabled");
    comma_en = 1'b1;
    ln = 0;
    send_word(KN); send_word(DB); send_word(DA); send_word(DB); send_word(DA);
    pad();
    exp_w[0] = DB; exp_w[1] = DA; exp_w[2] = DB; exp_w[3] = DA;
    exp_f[0] = 0; exp_f[1] = 0; exp_f[2] = 0; exp_f[3] = 0;
    analyze_realign("R4 enable raised");
  endtask

  task automatic t_complement();
    ln = 0;
    send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    send_word(KP); send_word(DA); send_word(KP); send_word(DA);
    pad();
    analyze_quiet("R3 inverted prefix ignored");
  endtask

  task automatic t_both_disparities();
    ln = 0;
    send_word(KN); send_word(DA); send_word(KP); send_word(DA); send_word(KN);
    pad();
    exp_w[0] = DA; exp_w[1] = KP; exp_w[2] = DA; exp_w[3] = KN;
    exp_f[0] = 0; exp_f[1] = 1; exp_f[2] = 0; exp_f[3] = 1;
    analyze_realign("R6 R9 both disparities");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_align();
    t_enable_low();
    t_complement();
    t_both_disparities();
    finish_run();
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog expired: actual 0 expected 1");
    finish_run();
  end
endmodule